// File: doc/BRIEF.md
# Buck gate timing controller

This block turns a handful of comparator flags into the two switch commands of a fixed-frequency synchronous buck converter. A cycle-start tick begins every switching period. The high-side switch conducts until the PWM comparator ends the on-time. The low-side switch then conducts after a guard interval in which both switches are off. All intervals are counted in ticks of the fast clock that runs the block.

The low side always conducts for a minimum blanking window. After that window, an undercurrent flag shuts it off until the next period, which gives discontinuous operation. If the flag stays clear, the low side stays on until the period ends, which gives continuous operation. A peak-overcurrent flag cuts the on-time short. When the bootstrap supply reads low at four consecutive period boundaries during full duty, the block inserts one short low-side refresh pulse and then goes back to full duty. A period that starts at zero duty drives nothing, unless the bootstrap reads low, in which case it issues one refresh pulse. A feedback overvoltage latch with two thresholds stops all switching.

Top module: `buck_gate_timer`

## Requirements
- R1: While `rst` is high, and in every sample after it is released until the first cycle start, `hs_gate` and `ls_gate` are both 0.
- R2: At a cycle start with `pwm_done` low, `hs_gate` goes to 1 in the sample after that edge if both gates were off and idle. If the low side was on, both gates are first off for DEAD_TICKS samples.
- R3: When `pwm_done` is high while the high side is on, `hs_gate` falls at the next edge. Both gates then stay off for exactly DEAD_TICKS samples, and then `ls_gate` rises.
- R4: `hs_gate` and `ls_gate` are never 1 together. Before either gate rises, both gates have been 0 for at least DEAD_TICKS consecutive samples.
- R5: Once the low side turns on after an on-time, it stays on for LS_MIN_TICKS samples whatever `i_under` does. If `i_under` is high at the end of that window, it turns off. Otherwise it stays on (continuous mode), and it turns off at the first later edge that sees `i_under` high or at the next cycle start.
- R6: The full-duty boundary count works as follows. A cycle start at which the high side is on and `boot_weak` is high increments it. Any other cycle start clears it. When such a start finds the count already at BOOT_CYCLES, the block runs: high side off, DEAD_TICKS samples with both gates off, `ls_gate` on for LS_MIN_TICKS samples, DEAD_TICKS samples with both gates off, then `hs_gate` on again. The count restarts from zero.
- R7: A cycle start with `pwm_done` already high is zero duty. No high-side pulse occurs in that period. If `boot_weak` is also high, exactly one `ls_gate` pulse of LS_MIN_TICKS samples is issued; otherwise both gates stay off.
- R8: `i_peak` high while the high side is on ends the on-time just as `pwm_done` does (R3). The high side stays off until the next cycle start, even if `i_peak` clears.
- R9: `fb_above_hi` sets an inhibit latch, and both gates are off from the second edge onward. While the latch is set, cycle starts are ignored. Only `fb_below_lo` clears the latch, and switching resumes at the first cycle start after the clearing edge.
- R10: A low side turned off by `i_under` stays off until the next cycle start, even if `i_under` clears in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | One-clock tick that begins a switching period |
| pwm_done | input | 1 | PWM comparator: high once the on-time is over |
| i_under | input | 1 | Inductor current below the undercurrent threshold |
| i_peak | input | 1 | High-side peak current above its limit |
| boot_weak | input | 1 | Bootstrap supply below its minimum |
| fb_above_hi | input | 1 | Feedback above the upper overvoltage threshold |
| fb_below_lo | input | 1 | Feedback below the lower release threshold |
| hs_gate | output | 1 | High-side switch command |
| ls_gate | output | 1 | Low-side switch command |

## Verification
Both gates are decoded from one state register. A reaction to a stimulus sampled at an edge therefore shows in the sample right after that edge. The exceptions are the guard interval, which adds DEAD_TICKS samples, the blanking and refresh pulses, which last LS_MIN_TICKS samples, and the overvoltage latch, which adds one extra edge because it is registered. Inputs are driven 2 ns after a rising edge and outputs are read at the same point. Every directed check sits on the sample index given by these counts, starting from the edge that captured the stimulus. The random phase checks sample by sample that the gates never overlap and that at least DEAD_TICKS off samples come before every rise.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

    // Sequencer states: which switch conducts, or which guard/idle phase runs
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HIGH  = 3'd1,
        ST_GAP   = 3'd2,
        ST_BLANK = 3'd3,
        ST_LOW   = 3'd4,
        ST_BOOT  = 3'd5
    } gate_st_e;

    // Comparator and timing inputs sampled each clock
    typedef struct packed {
        logic start;
        logic on_end;
        logic under;
        logic peak;
        logic boot_low;
    } cyc_sense_t;

    function automatic logic low_side_on(gate_st_e s);
        return (s == ST_BLANK) || (s == ST_LOW) || (s == ST_BOOT);
    endfunction

    function automatic logic high_side_on(gate_st_e s);
        return s == ST_HIGH;
    endfunction

    function automatic int tick_bits(int a, int b);
        return $clog2(((a > b) ? a : b) + 1);
    endfunction

endpackage

// File: rtl/buck_ov_gate.sv
module buck_ov_gate (
    input  logic clk,
    input  logic rst,
    input  logic above_hi,
    input  logic below_lo,
    output logic inhibit
);
    // Two-threshold latch: upper crossing sets, lower crossing releases
    always_ff @(posedge clk) begin
        if (rst)
            inhibit <= 1'b0;
        else if (above_hi)
            inhibit <= 1'b1;
        else if (below_lo)
            inhibit <= 1'b0;
    end

    // R9: a fresh upper crossing always leaves the latch set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (above_hi && below_lo) |=> inhibit);

endmodule

// File: rtl/buck_boot_watch.sv
module buck_boot_watch
    import buck_gate_pkg::*;
#(
    parameter int BOOT_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  cyc_sense_t sense,
    input  logic       inhibit,
    input  logic       high_on,
    output logic       refresh
);
    localparam int BW = $clog2(BOOT_CYCLES + 1);
    localparam logic [BW-1:0] LIMIT = BW'(BOOT_CYCLES);

    logic [BW-1:0] low_cnt_q;
    logic          full_low;

    // A boundary counts only when the high side carried the whole period
    assign full_low = sense.start && !inhibit && !sense.on_end
                      && sense.boot_low && high_on;
    assign refresh  = full_low && (low_cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || inhibit)
            low_cnt_q <= '0;
        else if (sense.start) begin
            if (full_low && (low_cnt_q != LIMIT))
                low_cnt_q <= low_cnt_q + BW'(1);
            else
                low_cnt_q <= '0;
        end
    end

    // R6: a healthy bootstrap at a cycle start clears the count
    a_r6_clear_on_good: assert property (@(posedge clk) disable iff (rst)
        (sense.start && !sense.boot_low) |=> (low_cnt_q == '0));

    // R6: a refresh request leaves the count empty
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        refresh |=> (low_cnt_q == '0));

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
    import buck_gate_pkg::*;
#(
    parameter int DEAD_TICKS   = 3,
    parameter int LS_MIN_TICKS = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  cyc_sense_t sense,
    input  logic       inhibit,
    input  logic       boot_refresh,
    output logic       hs_o,
    output logic       ls_o
);
    localparam int CW = tick_bits(DEAD_TICKS, LS_MIN_TICKS);
    localparam logic [CW-1:0] GAP_LD   = CW'(DEAD_TICKS - 1);
    localparam logic [CW-1:0] LOW_LD   = CW'(LS_MIN_TICKS - 1);
    localparam logic [CW-1:0] GAP_SAT  = CW'(DEAD_TICKS);
    localparam logic [CW-1:0] CZ       = '0;

    gate_st_e      st_q, st_n;
    gate_st_e      tgt_q, tgt_n;
    gate_st_e      want;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          ret_q, ret_n;
    logic          want_v;
    logic          drop;

    always_comb begin
        st_n   = st_q;
        tgt_n  = tgt_q;
        cnt_n  = cnt_q;
        ret_n  = ret_q;
        want_v = 1'b0;
        want   = ST_IDLE;
        drop   = 1'b0;

        // Progress within the period
        case (st_q)
            ST_HIGH: begin
                if (sense.on_end || sense.peak) begin
                    st_n  = ST_GAP;
                    tgt_n = ST_BLANK;
                    cnt_n = GAP_LD;
                end
            end
            ST_GAP: begin
                if (cnt_q == CZ) begin
                    st_n  = tgt_q;
                    cnt_n = LOW_LD;
                end else begin
                    cnt_n = cnt_q - CW'(1);
                end
            end
            ST_BLANK: begin
                if (cnt_q == CZ) begin
                    if (sense.under) begin
                        st_n  = ST_GAP;
                        tgt_n = ST_IDLE;
                        cnt_n = GAP_LD;
                    end else begin
                        st_n = ST_LOW;
                    end
                end else begin
                    cnt_n = cnt_q - CW'(1);
                end
            end
            ST_LOW: begin
                if (sense.under) begin
                    st_n  = ST_GAP;
                    tgt_n = ST_IDLE;
                    cnt_n = GAP_LD;
                end
            end
            ST_BOOT: begin
                if (cnt_q == CZ) begin
                    st_n  = ST_GAP;
                    tgt_n = ret_q ? ST_HIGH : ST_IDLE;
                    cnt_n = GAP_LD;
                end else begin
                    cnt_n = cnt_q - CW'(1);
                end
            end
            default: ;
        endcase

        // Period boundary and inhibit decisions
        if (inhibit) begin
            drop = 1'b1;
        end else if (sense.start) begin
            if (sense.on_end) begin
                if (sense.boot_low) begin
                    want_v = 1'b1;
                    want   = ST_BOOT;
                    ret_n  = 1'b0;
                end else begin
                    drop = 1'b1;
                end
            end else if (boot_refresh) begin
                want_v = 1'b1;
                want   = ST_BOOT;
                ret_n  = 1'b1;
            end else begin
                want_v = 1'b1;
                want   = ST_HIGH;
            end
        end

        if (drop) begin
            if (st_q == ST_GAP) begin
                tgt_n = ST_IDLE;
                if (cnt_q == CZ)
                    st_n = ST_IDLE;
            end else if (st_q != ST_IDLE) begin
                st_n  = ST_GAP;
                tgt_n = ST_IDLE;
                cnt_n = GAP_LD;
            end
        end else if (want_v) begin
            if (st_q == ST_GAP) begin
                tgt_n = want;
                if (cnt_q == CZ)
                    st_n = want;
            end else if ((st_q == ST_IDLE) ||
                         ((want == ST_BOOT) ? low_side_on(st_q)
                                            : high_side_on(st_q))) begin
                st_n  = want;
                cnt_n = LOW_LD;
            end else begin
                st_n  = ST_GAP;
                tgt_n = want;
                cnt_n = GAP_LD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            tgt_q <= ST_IDLE;
            cnt_q <= '0;
            ret_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            tgt_q <= tgt_n;
            cnt_q <= cnt_n;
            ret_q <= ret_n;
        end
    end

    assign hs_o = high_side_on(st_q);
    assign ls_o = low_side_on(st_q);

    // Off-run length observed at the outputs, used only by the checks below
    logic [CW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)
            gap_q <= GAP_SAT;
        else if (hs_o || ls_o)
            gap_q <= '0;
        else if (gap_q != GAP_SAT)
            gap_q <= gap_q + CW'(1);
    end

    // R4: never both switches at once
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hs_o && ls_o));

    // R4: any turn-on is preceded by a full guard interval
    a_r4_guard: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_o) || $rose(ls_o)) |-> (gap_q >= GAP_SAT));

    // R5: blanking keeps the low side on
    a_r5_blank_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BLANK && cnt_q != CZ && !sense.start && !inhibit) |=> ls_o);

    // R8: peak current removes the high side at the next edge
    a_r8_peak_cut: assert property (@(posedge clk) disable iff (rst)
        (hs_o && sense.peak && !sense.start) |=> !hs_o);

    // R9: nothing turns on while inhibited
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (inhibit && !hs_o && !ls_o) |=> (!hs_o && !ls_o));

    // R10: latched-off stays off between cycle starts
    a_r10_latch: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !sense.start) |=> (!hs_o && !ls_o));

    // R6: a full-duty refresh drops the high side at once
    a_r6_hs_drop: assert property (@(posedge clk) disable iff (rst)
        (sense.start && boot_refresh && !inhibit && !sense.on_end) |=> !hs_o);

endmodule

// File: rtl/buck_gate_timer.sv
module buck_gate_timer
    import buck_gate_pkg::*;
#(
    parameter int DEAD_TICKS   = 3,
    parameter int LS_MIN_TICKS = 5,
    parameter int BOOT_CYCLES  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic pwm_done,
    input  logic i_under,
    input  logic i_peak,
    input  logic boot_weak,
    input  logic fb_above_hi,
    input  logic fb_below_lo,
    output logic hs_gate,
    output logic ls_gate
);
    cyc_sense_t sense;
    logic       inhibit;
    logic       refresh;
    logic       hs_w;
    logic       ls_w;

    assign sense = '{start:    cyc_start,
                     on_end:   pwm_done,
                     under:    i_under,
                     peak:     i_peak,
                     boot_low: boot_weak};

    buck_ov_gate u_ov (
        .clk      (clk),
        .rst      (rst),
        .above_hi (fb_above_hi),
        .below_lo (fb_below_lo),
        .inhibit  (inhibit)
    );

    buck_boot_watch #(
        .BOOT_CYCLES (BOOT_CYCLES)
    ) u_boot (
        .clk     (clk),
        .rst     (rst),
        .sense   (sense),
        .inhibit (inhibit),
        .high_on (hs_w),
        .refresh (refresh)
    );

    buck_gate_seq #(
        .DEAD_TICKS   (DEAD_TICKS),
        .LS_MIN_TICKS (LS_MIN_TICKS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .sense        (sense),
        .inhibit      (inhibit),
        .boot_refresh (refresh),
        .hs_o         (hs_w),
        .ls_o         (ls_w)
    );

    assign hs_gate = hs_w;
    assign ls_gate = ls_w;

endmodule

// File: tb/sim_buck_gate_timer.sv
module sim_buck_gate_timer;
    localparam int DEAD = 3;
    localparam int LMIN = 5;
    localparam int BCYC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, pe = 1'b1, uc = 1'b0, oc = 1'b0, bl = 1'b0;
    logic ovh = 1'b0, ovl = 1'b0;
    logic hs, ls;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    buck_gate_timer #(.DEAD_TICKS(DEAD), .LS_MIN_TICKS(LMIN), .BOOT_CYCLES(BCYC)) u0 (
        .clk(clk), .rst(rst), .cyc_start(cs), .pwm_done(pe), .i_under(uc),
        .i_peak(oc), .boot_weak(bl), .fb_above_hi(ovh), .fb_below_lo(ovl),
        .hs_gate(hs), .ls_gate(ls)
    );

    // Expected length of the off-on-off sequence of a full-duty refresh
    function automatic int refresh_span();
        return 2 * DEAD + LMIN;
    endfunction

    // Random-phase rule: rising gate must follow DEAD off samples
    function automatic bit guard_ok(int off_run);
        return off_run >= DEAD;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic eh, input logic el);
        n_vec++;
        if (hs !== eh || ls !== el) begin
            n_bad++;
            $display("FAIL %s: hs/ls=%b%b expected %b%b at %0t", tag, hs, ls, eh, el, $time);
        end
    endtask

    task automatic run(input string tag, input int n, input logic eh, input logic el);
        for (int i = 0; i < n; i++) begin
            tick();
            chk(tag, eh, el);
        end
    endtask

    task automatic start_pulse(input string tag, input logic eh, input logic el);
        cs = 1'b1;
        tick();
        chk(tag, eh, el);
        cs = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        logic ph, pl;
        int gap;
        bit pat [6];

        seed_v = $urandom(32'd1973);
        #2;
        repeat (3) tick();
        chk("R1 in reset", 1'b0, 1'b0);
        rst = 1'b0;
        run("R1 after reset", 3, 1'b0, 1'b0);

        // Continuous mode period
        pe = 1'b0; uc = 1'b0;
        start_pulse("R2 hs from idle", 1'b1, 1'b0);
        run("R2 hs held", 4, 1'b1, 1'b0);
        pe = 1'b1;
        run("R3 guard after on-time", DEAD, 1'b0, 1'b0);
        run("R5 ccm low side", LMIN + 6, 1'b0, 1'b1);
        pe = 1'b0;
        start_pulse("R4 guard before hs", 1'b0, 1'b0);
        run("R4 guard before hs", DEAD - 1, 1'b0, 1'b0);
        run("R2 hs after guard", 3, 1'b1, 1'b0);

        // Discontinuous mode with latch-off
        uc = 1'b1; pe = 1'b1;
        run("R3 guard dcm", DEAD, 1'b0, 1'b0);
        run("R5 blanking holds low side", LMIN, 1'b0, 1'b1);
        run("R10 latch off", 1, 1'b0, 1'b0);
        uc = 1'b0;
        run("R10 stays off", 8, 1'b0, 1'b0);
        pe = 1'b0;
        start_pulse("R2 hs restart", 1'b1, 1'b0);

        // Peak overcurrent
        oc = 1'b1;
        tick();
        chk("R8 peak cuts hs", 1'b0, 1'b0);
        oc = 1'b0;
        run("R8 guard", DEAD - 1, 1'b0, 1'b0);
        run("R8 hs stays off", 6, 1'b0, 1'b1);

        // Zero duty, no refresh then with refresh
        pe = 1'b1; bl = 1'b0;
        start_pulse("R7 zero duty off", 1'b0, 1'b0);
        run("R7 zero duty quiet", 10, 1'b0, 1'b0);
        bl = 1'b1;
        start_pulse("R7 zero duty refresh", 1'b0, 1'b1);
        run("R7 refresh width", LMIN - 1, 1'b0, 1'b1);
        run("R7 single refresh", 10, 1'b0, 1'b0);

        // Full duty with weak bootstrap
        pe = 1'b0; bl = 1'b1;
        for (int k = 0; k < BCYC + 1; k++) begin
            start_pulse("R6 full duty", 1'b1, 1'b0);
            run("R6 full duty", 9, 1'b1, 1'b0);
        end
        start_pulse("R6 refresh hs off", 1'b0, 1'b0);
        run("R6 refresh guard", DEAD - 1, 1'b0, 1'b0);
        run("R6 refresh pulse", LMIN, 1'b0, 1'b1);
        run("R6 return guard", DEAD, 1'b0, 1'b0);
        run("R6 back to full duty", refresh_span() - 2 * DEAD - LMIN + 4, 1'b1, 1'b0);

        // Count restart after a good boundary
        pat = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
        for (int k = 0; k < 6; k++) begin
            bl = pat[k];
            start_pulse("R6 count cleared", 1'b1, 1'b0);
            bl = 1'b1;
            run("R6 count cleared", 9, 1'b1, 1'b0);
        end
        start_pulse("R6 refresh after restart", 1'b0, 1'b0);
        run("R6 refresh after restart", DEAD - 1, 1'b0, 1'b0);
        run("R6 refresh after restart", LMIN, 1'b0, 1'b1);
        run("R6 refresh after restart", DEAD, 1'b0, 1'b0);
        run("R6 refresh after restart", 3, 1'b1, 1'b0);

        // Overvoltage inhibit with hysteresis
        bl = 1'b0;
        ovh = 1'b1;
        run("R9 latch delay", 1, 1'b1, 1'b0);
        run("R9 switching stopped", 1, 1'b0, 1'b0);
        ovh = 1'b0;
        start_pulse("R9 start ignored", 1'b0, 1'b0);
        run("R9 still inhibited", 10, 1'b0, 1'b0);
        ovl = 1'b1;
        run("R9 release", 1, 1'b0, 1'b0);
        ovl = 1'b0;
        run("R9 waits for start", 2, 1'b0, 1'b0);
        start_pulse("R9 resumes", 1'b1, 1'b0);

        // Random phase: exclusivity and guard interval
        ph = hs; pl = ls; gap = (hs || ls) ? 0 : DEAD;
        for (int t = 0; t < 4000; t++) begin
            cs = ($urandom % 12) == 0;
            if (cs) pe = ($urandom % 8) == 0;
            else if (($urandom % 6) == 0) pe = 1'b1;
            uc  = ($urandom % 3) == 0;
            oc  = ($urandom % 40) == 0;
            if (($urandom % 20) == 0) bl = ~bl;
            ovh = ($urandom % 300) == 0;
            ovl = ($urandom % 25) == 0;
            tick();
            n_vec++;
            if (hs && ls) begin
                n_bad++;
                $display("FAIL R4 overlap: hs/ls=%b%b expected not 11 at %0t", hs, ls, $time);
            end
            if ((hs && !ph) || (ls && !pl)) begin
                n_vec++;
                if (!guard_ok(gap)) begin
                    n_bad++;
                    $display("FAIL R4 guard: off run %0d expected >= %0d at %0t", gap, DEAD, $time);
                end
            end
            gap = (hs || ls) ? 0 : gap + 1;
            ph = hs; pl = ls;
        end

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule